// File: doc/BRIEF.md
# Region-Based Two-Level Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address, or into a fault code. The two top address bits pick a region: a user program region that grows upward, a user stack region that grows downward, a shared system region, or a reserved code that is never translated. System pages are looked up in one table held in physical memory. That table's place is given by a base input, and its size by a length input.

The two user regions keep their page tables inside system virtual space. A user lookup therefore first forms the virtual address of its table entry, from the region's base input plus four times the page number. It translates that address through the system table, and only then reads the user entry from the physical address it obtained. Entries are read through a one-request, one-response memory port. A lookup starts with a single-cycle `req_valid` pulse while `busy` is low. The result appears with a single-cycle `done` pulse. The table base and length inputs must stay steady while `busy` is high.

Top module: `vat_xlate`

## Requirements
- R1: Virtual address bits [31:30] select the region: 00 program, 01 stack, 10 system, 11 reserved. A reserved address ends with fault code 5 and issues no memory fetch.
- R2: A system address fetches one entry, at `sys_base + 4*vpn`, where vpn is bits [29:9].
- R3: A system address whose vpn is not below `sys_len` ends with fault code 1 and issues no fetch.
- R4: A program address whose vpn is not below `prog_len` ends with fault code 1 and issues no fetch. Otherwise its entry virtual address is `prog_base + 4*vpn`. That address is translated through the system table, and then the user entry is read, for two fetches in all.
- R5: A stack address is checked from the top down. A vpn below `stack_len` ends with fault code 1 and issues no fetch. Otherwise it is looked up as in R4, with `stack_base`.
- R6: For a user lookup, bits [29:9] of the entry virtual address index the system table. If that index is not below `sys_len`, the lookup ends with fault code 1 and issues no fetch.
- R7: Entry bit 31 is the valid bit. If a system-level entry is invalid, the lookup ends with fault code 2. If a user-level entry is invalid, it ends with fault code 3.
- R8: Entry bits [30:27] are the protection field. Bit 27+m permits mode m, with modes 0 kernel, 1 executive, 2 supervisor and 3 user. Only the final entry of a lookup is checked. A denied access ends with fault code 4.
- R9: On success `pa` = {entry bits [20:0], address bits [8:0]} and the fault code is 0. On any fault `pa` is 0.
- R10: `done` is a single-cycle pulse. It rises in the cycle after the final `mem_rvalid`, or two cycles after the accepting edge when the lookup faults before any fetch. `busy` is high from acceptance until `done`.
- R11: Each fetch is a one-cycle `mem_req` pulse, and at most one fetch is outstanding.
- R12: After reset, `busy`, `done` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup (taken when not busy) |
| req_va | input | 32 | Virtual address |
| req_mode | input | 2 | Access mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| sys_base | input | 32 | Physical address of the system table |
| sys_len | input | 22 | Number of system table entries |
| prog_base | input | 32 | System-space virtual address of the program table |
| prog_len | input | 22 | Program region length in pages |
| stack_base | input | 32 | System-space virtual address of the stack table |
| stack_len | input | 22 | Lowest valid stack page number |
| mem_req | output | 1 | Entry fetch request pulse |
| mem_addr | output | 32 | Physical address of the entry to fetch |
| mem_rvalid | input | 1 | Fetched entry is on `mem_rdata` |
| mem_rdata | input | 32 | Fetched entry |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Result pulse |
| fault_code | output | 3 | 0 ok, 1 length, 2 invalid system entry, 3 invalid user entry, 4 protection, 5 reserved |
| pa | output | 30 | Physical address |

## Verification
The assertions check, on every cycle, the properties that hold for any lookup. `done` and `mem_req` stay single-cycle pulses. No fetch is ever made for a reserved address. A successful stack or system result never lies outside its length bound. A successful `pa` keeps the page offset, and a faulting `pa` is zero. Only the bench scenarios can show that the nested walk reads the right words of a populated table. They also show that the two invalid levels are told apart, that the protection bit for each mode is honoured, and that the top-down stack check and the entry-address length check trip exactly at their boundaries. The fetch counts and cycle latencies are checked there as well.

// File: rtl/vat_pkg.sv
`timescale 1ns/1ps
package vat_pkg;
  typedef enum logic [1:0] {
    RG_PROG  = 2'b00,
    RG_STACK = 2'b01,
    RG_SYS   = 2'b10,
    RG_RSVD  = 2'b11
  } region_e;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_LENGTH  = 3'd1,
    FLT_INV_SYS = 3'd2,
    FLT_INV_USR = 3'd3,
    FLT_PROT    = 3'd4,
    FLT_RSVD    = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT_SYS,
    ST_WAIT_USR
  } state_e;
endpackage

// File: rtl/vat_range_check.sv
`timescale 1ns/1ps
module vat_range_check
  import vat_pkg::*;
#(
  parameter int VPN_W = 21
) (
  input  region_e            region,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [VPN_W-1:0]   eva_vpn,
  input  logic [VPN_W:0]     sys_len,
  input  logic [VPN_W:0]     prog_len,
  input  logic [VPN_W:0]     stack_len,
  output logic               va_in_range,
  output logic               eva_in_range
);
  logic [VPN_W:0] vpn_x;
  assign vpn_x = {1'b0, vpn};

  always_comb begin
    unique case (region)
      RG_PROG:  va_in_range = vpn_x < prog_len;
      RG_STACK: va_in_range = vpn_x >= stack_len;   // stack grows down
      RG_SYS:   va_in_range = vpn_x < sys_len;
      default:  va_in_range = 1'b0;
    endcase
  end

  // the user table entry address must land inside the system table
  assign eva_in_range = {1'b0, eva_vpn} < sys_len;
endmodule

// File: rtl/vat_pte_decode.sv
`timescale 1ns/1ps
module vat_pte_decode #(
  parameter int WORD_W = 32,
  parameter int PFN_W  = 21,
  parameter int MODE_W = 2
) (
  input  logic [WORD_W-1:0] entry,
  input  logic [MODE_W-1:0] mode,
  output logic              valid,
  output logic              allowed,
  output logic [PFN_W-1:0]  pfn
);
  localparam int VALID_BIT = WORD_W - 1;
  localparam int PROT_W    = 1 << MODE_W;
  localparam int PROT_LO   = VALID_BIT - PROT_W;

  logic [PROT_W-1:0] prot;
  logic              unused_bits;

  assign valid       = entry[VALID_BIT];
  assign prot        = entry[PROT_LO +: PROT_W];
  assign allowed     = prot[mode];
  assign pfn         = entry[PFN_W-1:0];
  assign unused_bits = ^entry[PROT_LO-1:PFN_W];
endmodule

// File: rtl/vat_xlate.sv
`timescale 1ns/1ps
module vat_xlate
  import vat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 9,
  parameter int PFN_W  = 21,
  parameter int MODE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_va,
  input  logic [MODE_W-1:0]     req_mode,
  input  logic [VA_W-1:0]       sys_base,
  input  logic [VA_W-OFF_W-2:0] sys_len,
  input  logic [VA_W-1:0]       prog_base,
  input  logic [VA_W-OFF_W-2:0] prog_len,
  input  logic [VA_W-1:0]       stack_base,
  input  logic [VA_W-OFF_W-2:0] stack_len,
  output logic                  mem_req,
  output logic [VA_W-1:0]       mem_addr,
  input  logic                  mem_rvalid,
  input  logic [VA_W-1:0]       mem_rdata,
  output logic                  busy,
  output logic                  done,
  output logic [2:0]            fault_code,
  output logic [PFN_W+OFF_W-1:0] pa
);
  localparam int VPN_W = VA_W - OFF_W - 2;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_PAD = VA_W - VPN_W - 2;

  state_e             st;
  logic [VA_W-1:0]    va_q;
  logic [MODE_W-1:0]  mode_q;
  logic               user_q;
  logic [OFF_W-1:0]   eoff_q;

  region_e            region;
  logic [VPN_W-1:0]   vpn;
  logic               is_user;
  logic [VA_W-1:0]    user_base;
  logic [VA_W-1:0]    eva;
  logic [VPN_W-1:0]   eva_vpn;
  logic [VPN_W-1:0]   sys_idx;
  logic [VA_W-1:0]    sys_fetch_addr;
  logic [VA_W-1:0]    usr_fetch_addr;
  logic               va_ok, eva_ok;
  logic               pte_valid, pte_allowed;
  logic [PFN_W-1:0]   pte_pfn;

  assign region    = region_e'(va_q[VA_W-1 -: 2]);
  assign vpn       = va_q[OFF_W +: VPN_W];
  assign is_user   = (region == RG_PROG) || (region == RG_STACK);
  assign user_base = (region == RG_STACK) ? stack_base : prog_base;
  assign eva       = user_base + {{IDX_PAD{1'b0}}, vpn, 2'b00};
  assign eva_vpn   = eva[OFF_W +: VPN_W];
  assign sys_idx   = is_user ? eva_vpn : vpn;
  assign sys_fetch_addr = sys_base + {{IDX_PAD{1'b0}}, sys_idx, 2'b00};
  assign usr_fetch_addr = {{(VA_W-PA_W){1'b0}}, pte_pfn, eoff_q};
  assign busy      = (st != ST_IDLE);

  vat_range_check #(.VPN_W(VPN_W)) u_range (
    .region      (region),
    .vpn         (vpn),
    .eva_vpn     (eva_vpn),
    .sys_len     (sys_len),
    .prog_len    (prog_len),
    .stack_len   (stack_len),
    .va_in_range (va_ok),
    .eva_in_range(eva_ok)
  );

  vat_pte_decode #(.WORD_W(VA_W), .PFN_W(PFN_W), .MODE_W(MODE_W)) u_pte (
    .entry  (mem_rdata),
    .mode   (mode_q),
    .valid  (pte_valid),
    .allowed(pte_allowed),
    .pfn    (pte_pfn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      va_q       <= '0;
      mode_q     <= '0;
      user_q     <= 1'b0;
      eoff_q     <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      done       <= 1'b0;
      fault_code <= FLT_NONE;
      pa         <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            mode_q <= req_mode;
            st     <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (region == RG_RSVD) begin
            done <= 1'b1; fault_code <= FLT_RSVD; pa <= '0; st <= ST_IDLE;
          end else if (!va_ok || (is_user && !eva_ok)) begin
            done <= 1'b1; fault_code <= FLT_LENGTH; pa <= '0; st <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= sys_fetch_addr;
            user_q   <= is_user;
            eoff_q   <= eva[OFF_W-1:0];
            st       <= ST_WAIT_SYS;
          end
        end
        ST_WAIT_SYS: begin
          if (mem_rvalid) begin
            if (!pte_valid) begin
              done <= 1'b1; fault_code <= FLT_INV_SYS; pa <= '0; st <= ST_IDLE;
            end else if (user_q) begin
              mem_req  <= 1'b1;
              mem_addr <= usr_fetch_addr;
              st       <= ST_WAIT_USR;
            end else if (!pte_allowed) begin
              done <= 1'b1; fault_code <= FLT_PROT; pa <= '0; st <= ST_IDLE;
            end else begin
              done <= 1'b1; fault_code <= FLT_NONE;
              pa   <= {pte_pfn, va_q[OFF_W-1:0]}; st <= ST_IDLE;
            end
          end
        end
        ST_WAIT_USR: begin
          if (mem_rvalid) begin
            done <= 1'b1;
            st   <= ST_IDLE;
            if (!pte_valid) begin
              fault_code <= FLT_INV_USR; pa <= '0;
            end else if (!pte_allowed) begin
              fault_code <= FLT_PROT; pa <= '0;
            end else begin
              fault_code <= FLT_NONE; pa <= {pte_pfn, va_q[OFF_W-1:0]};
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: result strobe lasts exactly one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: each fetch request is a single-cycle pulse
  a_r11_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R1: reserved addresses never reach the memory port
  a_r1_no_rsvd_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (va_q[VA_W-1 -: 2] != 2'b11));

  // R5: a successful stack result lies at or above the stack limit
  a_r5_stack_floor: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == FLT_NONE && va_q[VA_W-1 -: 2] == 2'b01)
      |-> ({1'b0, va_q[OFF_W +: VPN_W]} >= stack_len));

  // R3: a successful system result lies below the system length
  a_r3_sys_bound: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == FLT_NONE && va_q[VA_W-1 -: 2] == 2'b10)
      |-> ({1'b0, va_q[OFF_W +: VPN_W]} < sys_len));

  // R9: success keeps the page offset, a fault clears the address
  a_r9_pa_offset: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code == FLT_NONE) |-> (pa[OFF_W-1:0] == va_q[OFF_W-1:0]));
  a_r9_pa_zero: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != FLT_NONE) |-> (pa == '0));
endmodule

// File: tb/tb_vat_xlate.sv
`timescale 1ns/1ps
module tb_vat_xlate;
  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  mode;
    logic [2:0]  flt;
    logic [29:0] pa;
    logic [1:0]  nf;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 18;
  // System table: 8 entries at 0x100. Program table page: frame 3.
  // Stack table page: frame 4. Stack limit 0x1FFF00.
  localparam vec_t VECS [NV] = '{
    '{32'h8000_01A5, 2'd3, 3'd0, 30'h0000_15A5, 2'd1, 4'd4},  // R2 sys ok
    '{32'h8000_0200, 2'd0, 3'd0, 30'h0000_1600, 2'd1, 4'd4},  // R8 kernel-only ok
    '{32'h8000_0200, 2'd3, 3'd4, 30'h0,         2'd1, 4'd4},  // R8 user denied
    '{32'h8000_0600, 2'd0, 3'd2, 30'h0,         2'd1, 4'd4},  // R7 sys invalid
    '{32'h8000_1000, 2'd0, 3'd1, 30'h0,         2'd0, 4'd2},  // R3 vpn == len
    '{32'h8000_0E00, 2'd0, 3'd2, 30'h0,         2'd1, 4'd4},  // R3 vpn == len-1
    '{32'h0000_00FF, 2'd3, 3'd0, 30'h0246_8AFF, 2'd2, 4'd6},  // R4 prog ok
    '{32'h0000_0200, 2'd3, 3'd3, 30'h0,         2'd2, 4'd6},  // R7 user invalid
    '{32'h0000_0400, 2'd3, 3'd4, 30'h0,         2'd2, 4'd6},  // R8 user denied
    '{32'h0000_0400, 2'd0, 3'd0, 30'h0000_EE00, 2'd2, 4'd6},  // R8 kernel ok
    '{32'h0000_07FF, 2'd1, 3'd0, 30'h3FFF_FFFF, 2'd2, 4'd6},  // R9 max frame
    '{32'h0000_0800, 2'd0, 3'd1, 30'h0,         2'd0, 4'd2},  // R4 length
    '{32'hC000_0000, 2'd0, 3'd5, 30'h0,         2'd0, 4'd2},  // R1 reserved
    '{32'h7FFF_0010, 2'd2, 3'd0, 30'h0015_7810, 2'd2, 4'd6},  // R5 stack ok
    '{32'h7FFF_FFFF, 2'd3, 3'd0, 30'h0002_ABFF, 2'd2, 4'd6},  // R5 top page
    '{32'h7FFF_FFFF, 2'd0, 3'd4, 30'h0,         2'd2, 4'd6},  // R8 user-only page
    '{32'h7FFD_FE00, 2'd0, 3'd1, 30'h0,         2'd0, 4'd2},  // R5 below limit
    '{32'h7FFE_0000, 2'd0, 3'd2, 30'h0,         2'd1, 4'd4}   // R5 at limit, R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_mode = '0;
  logic [31:0] sys_base, prog_base, stack_base;
  logic [21:0] sys_len, prog_len, stack_len;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done;
  logic [2:0]  fault_code;
  logic [29:0] pa;

  logic [31:0] mem [1024];
  int          nfetch = 0;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  vat_xlate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_mode(req_mode), .sys_base(sys_base), .sys_len(sys_len),
    .prog_base(prog_base), .prog_len(prog_len), .stack_base(stack_base),
    .stack_len(stack_len), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .fault_code(fault_code), .pa(pa)
  );

  // one-cycle-latency table memory
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[11:2]];
    if (mem_req) nfetch <= nfetch + 1;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string vec_tag(input vec_t v);
    if (v.va[31:30] == 2'b11) return "R1";
    case (v.flt)
      3'd1: return (v.va[31:30] == 2'b01) ? "R5" : (v.va[31:30] == 2'b00) ? "R4" : "R3";
      3'd2, 3'd3: return "R7";
      3'd4: return "R8";
      default: return (v.va[31:30] == 2'b10) ? "R2" : "R4";
    endcase
  endfunction

  task automatic run(input vec_t v);
    int f0;
    int lat;
    string t;
    t = vec_tag(v);
    @(negedge clk);
    req_va = v.va; req_mode = v.mode; req_valid = 1'b1;
    f0 = nfetch;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(fault_code == v.flt, {t, " fault"}, fault_code, v.flt);
    chk(pa == v.pa, {t, " R9 pa"}, pa, v.pa);
    chk((nfetch - f0) == int'(v.nf), {t, " R11 fetches"}, nfetch - f0, v.nf);
    chk(lat == int'(v.lat), "R10 latency", lat, v.lat);
    @(negedge clk);
    chk(!done && !busy, "R10 done pulse", {done, busy}, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[64] = 32'hF800_000A;  // sys 0: all modes, frame 10
    mem[65] = 32'h8800_000B;  // sys 1: kernel only, frame 11
    mem[66] = 32'hF800_0003;  // sys 2: program table page
    mem[68] = 32'hF800_0004;  // sys 4: stack table page
    mem[384] = 32'hF801_2345; // prog 0
    mem[386] = 32'h8800_0077; // prog 2 kernel only
    mem[387] = 32'hF81F_FFFF; // prog 3 max frame
    mem[512] = 32'hF800_0ABC; // stack 0x1FFF80
    mem[639] = 32'hC000_0155; // stack 0x1FFFFF user only
    sys_base   = 32'h0000_0100;
    sys_len    = 22'd8;
    prog_base  = 32'h8000_0400;
    prog_len   = 22'd4;
    stack_base = 32'h8000_0600 - (32'h001F_FF00 << 2);
    stack_len  = 22'h1F_FF00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !mem_req, "R12 reset", {busy, done, mem_req}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run(VECS[i]);

    // R6: entry address page beyond the system table length
    sys_len = 22'd2;
    run('{32'h0000_00FF, 2'd3, 3'd1, 30'h0, 2'd0, 4'd2});
    chk(fault_code == 3'd1, "R6 entry length", fault_code, 1);
    sys_len = 22'd8;

    // request held high during a walk is not taken twice
    @(negedge clk);
    req_va = 32'h8000_01A5; req_mode = 2'd0; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    chk(done && pa == 30'h15A5, "R10 held request", pa, 30'h15A5);
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule